// File: doc/BRIEF.md
# Bit-Oriented Frame Serializer/Deserializer

This block converts between whole bytes held in FIFOs and a serial bit stream whose frames need not start or end on a byte boundary, as used by bitwise anticollision exchanges. A small control register holds a start request, a receive bit offset and a count of bits to send from the final transmit byte. The FIFOs, line coding, modulation and CRC sit outside the block. The block meets the FIFOs through a pop strobe that is qualified by a data-available flag, and through a push strobe.

On transmit, a start request is taken only while the external transceive command is active. The block then pops `tx_len` bytes one at a time and shifts each byte out least significant bit first. It sends only the configured number of bits of the byte at index `tx_len`−1, then raises a one-cycle done pulse. The transmit FSM has four states:
- `TX_IDLE` moves to `TX_FETCH` on an accepted start, or to `TX_DONE` when the length is zero.
- `TX_FETCH` moves to `TX_SHIFT` when the FIFO has data.
- `TX_SHIFT` moves back to `TX_FETCH` after the last bit of a byte that is not the final one, and to `TX_DONE` after the last bit of the final byte.
- `TX_DONE` always returns to `TX_IDLE`.

On receive, the first bit of a frame is stored at the configured offset of the first byte, and the bit positions below that offset read as zero. Each later bit goes to the next higher position and wraps to bit 0 of a fresh byte. Each completed byte is pushed at once. When the frame ends, a partly filled byte is pushed together with its count of valid bits. The receive FSM has two states:
- `RX_IDLE` moves to `RX_FILL` on the first bit of a frame.
- `RX_FILL` returns to `RX_IDLE` on frame end.

Top module: `bitframe_serdes`

## Requirements
- R1: After reset the control register reads 0x00, and `tx_bit_valid`, `tx_done`, `txf_pop` and `rxf_push` are low.
- R2: A write stores bits 6:4 as the receive offset and bits 2:0 as the last-byte bit count. Bit 3 always reads 0, and bit 7 reads the pending start request.
- R3: Writing 1 to bit 7 sets the start request only while `xcv_active` is high and no frame is in progress. The request reads 1 for exactly one cycle and then clears itself. A start written while a frame is in progress is ignored.
- R4: A frame pops exactly `tx_len` bytes, pops only while `txf_valid` is high, and sends each byte least significant bit first on `tx_bit` with `tx_bit_valid` high.
- R5: The byte at index `tx_len`−1 sends only its low N bits, where N is the last-byte count taken at the start (0 means 8). All other bytes send all 8 bits.
- R6: `tx_done` is a single-cycle pulse, raised once per frame after the final bit and never in a cycle with `tx_bit_valid` high.
- R7: The first received bit of a frame is stored at the bit position given by the receive offset. Each later bit is stored at the next higher position, and after bit 7 storing continues at bit 0 of the next byte.
- R8: The bit positions below the receive offset in the first received byte are 0.
- R9: A completed byte is pushed with `rxf_bits` = 0, meaning 8 valid bits. On `rx_end`, a partly filled byte is pushed with `rxf_bits` equal to its count of valid bits (1 to 7), and nothing is pushed if no bits are pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register read value |
| xcv_active | input | 1 | Transceive command is active |
| tx_len | input | LEN_W | Transmit frame length in bytes |
| txf_valid | input | 1 | TX FIFO holds a byte |
| txf_data | input | 8 | TX FIFO head byte |
| txf_pop | output | 1 | Take the TX FIFO head byte |
| tx_bit | output | 1 | Serial transmit bit |
| tx_bit_valid | output | 1 | `tx_bit` carries a bit this cycle |
| tx_done | output | 1 | Transmit frame complete pulse |
| rx_bit | input | 1 | Serial receive bit |
| rx_bit_valid | input | 1 | `rx_bit` carries a bit this cycle |
| rx_end | input | 1 | Receive frame ended |
| rxf_push | output | 1 | Push a byte into the RX FIFO |
| rxf_data | output | 8 | Byte being pushed |
| rxf_bits | output | 3 | Valid bits in the pushed byte, 0 means 8 |

## Verification
The assertions take for granted that `rx_end` never arrives in the same cycle as a received bit, and one property checks this input rule. They also assume that `tx_len` and `txf_data` are stable while a frame runs and that the TX FIFO never runs dry part way through a frame. The bench keeps to these rules. It ends each receive frame with a separate `rx_end` cycle after the last bit, and it presents a constant, always-valid FIFO model whose contents and length are loaded before the start is written.

// File: rtl/bfs_pkg.sv
package bfs_pkg;
    localparam int BYTE_W = 8;
    localparam int POS_W  = $clog2(BYTE_W);

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_FETCH,
        TX_SHIFT,
        TX_DONE
    } tx_state_e;

    typedef enum logic {
        RX_IDLE,
        RX_FILL
    } rx_state_e;
endpackage

// File: rtl/bfs_ctrl.sv
module bfs_ctrl
    import bfs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              xcv_active,
    input  logic              tx_idle,
    input  logic              accept,
    output logic              start,
    output logic [POS_W-1:0]  align,
    output logic [POS_W-1:0]  last_bits,
    output logic [BYTE_W-1:0] rdata
);
    logic unused_rsvd;
    assign unused_rsvd = wdata[3];

    // a start is honoured only with transceive active and the transmitter free
    logic start_ok;
    assign start_ok = wdata[7] && xcv_active && tx_idle && !start;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start     <= 1'b0;
            align     <= '0;
            last_bits <= '0;
        end else begin
            if (accept)
                start <= 1'b0;
            if (we) begin
                align     <= wdata[6:4];
                last_bits <= wdata[2:0];
                if (start_ok)
                    start <= 1'b1;
            end
        end
    end

    assign rdata = {start, align, 1'b0, last_bits};
endmodule

// File: rtl/bfs_tx.sv
module bfs_tx
    import bfs_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [POS_W-1:0]  last_bits,
    input  logic [LEN_W-1:0]  frame_len,
    input  logic              fifo_valid,
    input  logic [BYTE_W-1:0] fifo_data,
    output logic              accept,
    output logic              idle,
    output logic              fifo_pop,
    output logic              ser_bit,
    output logic              ser_valid,
    output logic              done
);
    tx_state_e         state, state_nx;
    logic [BYTE_W-1:0] shreg;
    logic [POS_W-1:0]  bit_cnt;
    logic [POS_W-1:0]  nbits_m1;
    logic [POS_W-1:0]  lb_q;
    logic [LEN_W-1:0]  idx;
    logic [LEN_W-1:0]  len_q;
    logic              is_last;
    logic              byte_end;

    assign is_last  = (idx == len_q - 1'b1);
    assign byte_end = (bit_cnt == nbits_m1);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            TX_IDLE:  if (start) state_nx = (frame_len == '0) ? TX_DONE : TX_FETCH;
            TX_FETCH: if (fifo_valid) state_nx = TX_SHIFT;
            TX_SHIFT: if (byte_end) state_nx = is_last ? TX_DONE : TX_FETCH;
            TX_DONE:  state_nx = TX_IDLE;
        endcase
    end

    always_comb begin
        accept    = 1'b0;
        fifo_pop  = 1'b0;
        ser_valid = 1'b0;
        done      = 1'b0;
        unique case (state)
            TX_IDLE:  accept    = start;
            TX_FETCH: fifo_pop  = fifo_valid;
            TX_SHIFT: ser_valid = 1'b1;
            TX_DONE:  done      = 1'b1;
        endcase
    end
    assign idle    = (state == TX_IDLE);
    assign ser_bit = shreg[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg    <= '0;
            bit_cnt  <= '0;
            nbits_m1 <= '0;
            lb_q     <= '0;
            idx      <= '0;
            len_q    <= '0;
        end else begin
            if (accept) begin
                len_q <= frame_len;
                lb_q  <= last_bits;
                idx   <= '0;
            end
            if (fifo_pop) begin
                shreg    <= fifo_data;
                bit_cnt  <= '0;
                nbits_m1 <= (is_last && lb_q != '0) ? lb_q - 1'b1 : POS_W'(BYTE_W - 1);
            end
            if (ser_valid) begin
                shreg   <= shreg >> 1;
                bit_cnt <= bit_cnt + 1'b1;
                if (byte_end && !is_last)
                    idx <= idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/bfs_rx.sv
module bfs_rx
    import bfs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [POS_W-1:0]  align,
    input  logic              ser_bit,
    input  logic              ser_valid,
    input  logic              frame_end,
    output logic              push,
    output logic [BYTE_W-1:0] push_data,
    output logic [POS_W-1:0]  push_bits
);
    rx_state_e         state, state_nx;
    logic [BYTE_W-1:0] acc;
    logic [POS_W-1:0]  pos;
    logic [POS_W-1:0]  put_pos;
    logic [BYTE_W-1:0] merged;
    logic              word_full;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            RX_IDLE: if (ser_valid) state_nx = RX_FILL;
            RX_FILL: if (frame_end) state_nx = RX_IDLE;
        endcase
    end

    // the first bit of a frame lands at the offset, later ones follow on
    always_comb begin
        put_pos   = (state == RX_IDLE) ? align : pos;
        merged    = ((state == RX_IDLE) ? '0 : acc) | (BYTE_W'(ser_bit) << put_pos);
        word_full = (put_pos == POS_W'(BYTE_W - 1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc       <= '0;
            pos       <= '0;
            push      <= 1'b0;
            push_data <= '0;
            push_bits <= '0;
        end else begin
            push <= 1'b0;
            if (ser_valid) begin
                if (word_full) begin
                    push      <= 1'b1;
                    push_data <= merged;
                    push_bits <= '0;
                    acc       <= '0;
                    pos       <= '0;
                end else begin
                    acc <= merged;
                    pos <= put_pos + 1'b1;
                end
            end else if (state == RX_FILL && frame_end) begin
                if (pos != '0) begin
                    push      <= 1'b1;
                    push_data <= acc;
                    push_bits <= pos;
                end
                acc <= '0;
                pos <= '0;
            end
        end
    end
endmodule

// File: rtl/bitframe_serdes.sv
module bitframe_serdes
    import bfs_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              xcv_active,
    input  logic [LEN_W-1:0]  tx_len,
    input  logic              txf_valid,
    input  logic [7:0]        txf_data,
    output logic              txf_pop,
    output logic              tx_bit,
    output logic              tx_bit_valid,
    output logic              tx_done,
    input  logic              rx_bit,
    input  logic              rx_bit_valid,
    input  logic              rx_end,
    output logic              rxf_push,
    output logic [7:0]        rxf_data,
    output logic [2:0]        rxf_bits
);
    logic             start, accept, tx_idle;
    logic [POS_W-1:0] align, last_bits;

    bfs_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (cfg_we),
        .wdata      (cfg_wdata),
        .xcv_active (xcv_active),
        .tx_idle    (tx_idle),
        .accept     (accept),
        .start      (start),
        .align      (align),
        .last_bits  (last_bits),
        .rdata      (cfg_rdata)
    );

    bfs_tx #(.LEN_W(LEN_W)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .last_bits  (last_bits),
        .frame_len  (tx_len),
        .fifo_valid (txf_valid),
        .fifo_data  (txf_data),
        .accept     (accept),
        .idle       (tx_idle),
        .fifo_pop   (txf_pop),
        .ser_bit    (tx_bit),
        .ser_valid  (tx_bit_valid),
        .done       (tx_done)
    );

    bfs_rx u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .align      (align),
        .ser_bit    (rx_bit),
        .ser_valid  (rx_bit_valid),
        .frame_end  (rx_end),
        .push       (rxf_push),
        .push_data  (rxf_data),
        .push_bits  (rxf_bits)
    );
endmodule

// File: rtl/bfs_checker.sv
module bfs_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] cfg_rdata,
    input logic       xcv_active,
    input logic       txf_valid,
    input logic       txf_pop,
    input logic       tx_bit_valid,
    input logic       tx_done,
    input logic       rx_bit_valid,
    input logic       rx_end,
    input logic       rxf_push,
    input logic [2:0] rxf_bits
);
    p_start_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[7] |=> !cfg_rdata[7]);

    p_start_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_rdata[7]) |-> $past(xcv_active));

    p_pop_needs_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        txf_pop |-> txf_valid);

    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> !tx_done);

    p_done_no_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> !tx_bit_valid);

    p_partial_after_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rxf_push && rxf_bits != 3'd0) |-> $past(rx_end));

    p_end_apart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_end && rx_bit_valid));
endmodule

bind bitframe_serdes bfs_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_rdata    (cfg_rdata),
    .xcv_active   (xcv_active),
    .txf_valid    (txf_valid),
    .txf_pop      (txf_pop),
    .tx_bit_valid (tx_bit_valid),
    .tx_done      (tx_done),
    .rx_bit_valid (rx_bit_valid),
    .rx_end       (rx_end),
    .rxf_push     (rxf_push),
    .rxf_bits     (rxf_bits)
);

// File: tb/tb_bitframe_serdes.sv
module tb_bitframe_serdes;
    localparam int LEN_W = 8;

    // TX vector: [29:28] length, [26:24] last-byte bits, [23:0] bytes (byte 0 low)
    localparam logic [31:0] TXV [6] = '{
        32'h1000_00A5, 32'h1300_00B6, 32'h2000_3C5A,
        32'h2500_F00F, 32'h3712_34C9, 32'h3181_7E55
    };
    // RX vector: [30:28] offset, [20:16] bit count, [15:0] bits, first bit at [0]
    localparam logic [31:0] RXV [7] = '{
        32'h0008_00A5, 32'h0005_0013, 32'h3005_0015, 32'h7001_0001,
        32'h7003_0005, 32'h200D_1ABC, 32'h5010_BEEF
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic [7:0]       cfg_wdata = '0;
    logic [7:0]       cfg_rdata;
    logic             xcv_active = 1'b0;
    logic [LEN_W-1:0] tx_len = '0;
    logic             txf_valid = 1'b1;
    logic [7:0]       txf_data;
    logic             txf_pop;
    logic             tx_bit, tx_bit_valid, tx_done;
    logic             rx_bit = 1'b0, rx_bit_valid = 1'b0, rx_end = 1'b0;
    logic             rxf_push;
    logic [7:0]       rxf_data;
    logic [2:0]       rxf_bits;

    always #10 clk = ~clk;

    bitframe_serdes #(.LEN_W(LEN_W)) dut (.*);

    logic [7:0] tf [4];
    int         fidx = 0;
    assign txf_data = tf[fidx[1:0]];
    always @(posedge clk) if (txf_pop) fidx <= fidx + 1;

    logic       got [64];
    logic [7:0] rd [8];
    logic [2:0] rb [8];
    int ntx = 0, ndone = 0, nrx = 0;
    int checks = 0, errors = 0;

    always @(negedge clk) begin
        if (tx_bit_valid) begin
            if (ntx < 64) got[ntx] = tx_bit;
            ntx++;
        end
        if (tx_done) ndone++;
        if (rxf_push) begin
            if (nrx < 8) begin
                rd[nrx] = rxf_data;
                rb[nrx] = rxf_bits;
            end
            nrx++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d, input logic x);
        @(negedge clk);
        xcv_active = x;
        cfg_wdata  = d;
        cfg_we     = 1'b1;
        @(negedge clk);
        cfg_we     = 1'b0;
    endtask

    task automatic run_tx(input logic [31:0] v);
        int len, lb, k, bad, n;
        len = int'(v[29:28]);
        lb  = int'(v[26:24]);
        for (int i = 0; i < 3; i++) tf[i] = v[8*i +: 8];
        tf[3] = 8'h00;
        fidx = 0; ntx = 0; ndone = 0;
        tx_len = LEN_W'(len);
        wr({1'b1, 3'b000, 1'b0, 3'(lb)}, 1'b1);
        chk(cfg_rdata[7] == 1'b1, "R3 start set", int'(cfg_rdata[7]), 1);
        @(negedge clk);
        chk(cfg_rdata[7] == 1'b0, "R3 start self-clear", int'(cfg_rdata[7]), 0);
        for (int t = 0; t < 120 && ndone == 0; t++) @(negedge clk);
        repeat (4) @(negedge clk);
        k = 0; bad = 0;
        for (int i = 0; i < len; i++) begin
            n = (i == len - 1 && lb != 0) ? lb : 8;
            for (int b = 0; b < n; b++) begin
                if (k < 64 && got[k] !== tf[i][b]) bad++;
                k++;
            end
        end
        chk(ntx == k, "R5 bits sent", ntx, k);
        chk(bad == 0, "R4 LSB-first bit values", bad, 0);
        chk(fidx == len, "R4 bytes popped", fidx, len);
        chk(ndone == 1, "R6 done pulses", ndone, 1);
    endtask

    task automatic run_rx(input logic [31:0] v);
        int al, n, p, nb, lastc;
        logic [7:0] eb [4];
        al = int'(v[30:28]);
        n  = int'(v[20:16]);
        for (int j = 0; j < 4; j++) eb[j] = 8'h00;
        for (int k = 0; k < n; k++) begin
            p = al + k;
            eb[p / 8][p % 8] = v[k];
        end
        nb    = (al + n + 7) / 8;
        lastc = (al + n) % 8;
        wr({1'b0, 3'(al), 1'b0, 3'b000}, 1'b1);
        nrx = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            rx_bit_valid = 1'b1;
            rx_bit       = v[k];
        end
        @(negedge clk);
        rx_bit_valid = 1'b0;
        rx_end       = 1'b1;
        @(negedge clk);
        rx_end = 1'b0;
        repeat (3) @(negedge clk);
        chk(nrx == nb, "R9 bytes pushed", nrx, nb);
        for (int j = 0; j < nb && j < 8; j++) begin
            chk(rd[j] == eb[j], "R7 R8 received byte", int'(rd[j]), int'(eb[j]));
            chk(int'(rb[j]) == ((j == nb - 1) ? lastc : 0), "R9 valid-bit count",
                int'(rb[j]), (j == nb - 1) ? lastc : 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cfg_rdata == 8'h00, "R1 reg reset", int'(cfg_rdata), 0);
        chk(!tx_bit_valid && !tx_done && !txf_pop && !rxf_push, "R1 outputs idle",
            int'({tx_bit_valid, tx_done, txf_pop, rxf_push}), 0);

        // R2 fields and reserved bit, R3 start gated by xcv_active
        ntx = 0;
        wr(8'hFF, 1'b0);
        chk(cfg_rdata == 8'h77, "R2 R3 reg fields", int'(cfg_rdata), 8'h77);
        repeat (10) @(negedge clk);
        chk(ntx == 0, "R3 no send without transceive", ntx, 0);

        // table walk
        for (int i = 0; i < 6; i++) run_tx(TXV[i]);
        for (int i = 0; i < 7; i++) run_rx(RXV[i]);

        // R3 start ignored while a frame is running
        for (int i = 0; i < 3; i++) tf[i] = 8'h5A + 8'(i);
        fidx = 0; ntx = 0; ndone = 0;
        tx_len = LEN_W'(3);
        wr(8'h80, 1'b1);
        repeat (6) @(negedge clk);
        wr(8'h80, 1'b1);
        chk(cfg_rdata[7] == 1'b0, "R3 busy start ignored", int'(cfg_rdata[7]), 0);
        repeat (60) @(negedge clk);
        chk(ntx == 24, "R3 single frame bits", ntx, 24);
        chk(ndone == 1, "R3 R6 single done", ndone, 1);

        // R9 frame end with nothing pending pushes nothing
        nrx = 0;
        @(negedge clk); rx_end = 1'b1;
        @(negedge clk); rx_end = 1'b0;
        repeat (3) @(negedge clk);
        chk(nrx == 0, "R9 empty end no push", nrx, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule